// File: doc/BRIEF.md
# Clock Divider and Power Control

This block sits next to a clock-multiplying PLL and turns the fast internal clock into a divided clock enable. The ratio is a programmable power of two from 1 to 32768. The block also decides what happens to the PLL and the crystal oscillator around a low-power STOP state. It produces only clock enables and never a generated clock. The PLL itself is represented by a lock input and a settle counter.

Software writes one 24-bit control word in a single cycle. The word holds the following fields:
- a 12-bit multiplication factor in bits 11:0;
- a 4-bit division code in bits 15:12;
- a crystal-disable bit at bit 16;
- a keep-running-in-STOP bit at bit 17.

A new division code is staged and takes effect only when the running ratio completes an interval. The enable spacing therefore never shrinks. When the multiplication factor is 4 or less, the change also stalls the processor until the new ratio restarts on a reference-clock edge. When the factor is above 4, the new ratio starts directly with no stall. Division changes never disturb the PLL.

Top module: `clkdiv_pwrctl`

## Requirements
- R1: After reset the control word reads as zero, so the division code is 0 (divide by one). `div_en` is high in every cycle, `stall` is low, `pll_en` and `osc_en` are high, and `xtal_force_hi` is low.
- R2: With division code n in effect, `div_en` is a one-cycle pulse repeating every 2^n clock cycles (n = 0 gives a pulse in every cycle).
- R3: A written division code takes effect only at the end of the interval in progress. The interval that spans the write keeps the old length, and the following interval has the new length, whether the ratio grows or shrinks.
- R4: If a write carries a multiplication factor of 4 or less and a division code different from the one in effect, `stall` rises in the cycle after the write. After the interval in progress ends, `div_en` stays low until a cycle with `ref_edge` high. `stall` falls in the next cycle, and the first new pulse comes 2^n cycles after the `ref_edge` cycle.
- R5: A write with a multiplication factor above 4 never raises `stall`. Its division code applies at the interval end without waiting for `ref_edge`.
- R6: `ckout_en` is high in exactly the cycles where `div_en` is high, for every multiplication factor.
- R7: Bit 16 set drives `xtal_force_hi` high and `xtal_drv_en` low. With bit 16 clear, `xtal_force_hi` is low and `xtal_drv_en` follows `osc_en`.
- R8: With bit 17 set, `stop_req` high keeps `pll_en` and `osc_en` high and `div_en` low from the cycle after `stop_req` is first seen. After `stop_req` drops, counting restarts and the first pulse comes 2^n cycles after the last STOP cycle.
- R9: With bit 17 clear, `pll_en`, `osc_en` and `xtal_drv_en` go low in the cycle after `stop_req` is first seen. After `stop_req` drops, the enables return at once. `div_en` stays low until `pll_lock` has been high for SETTLE_CYC consecutive cycles, and the first pulse comes SETTLE_CYC cycles after `pll_lock` rises (division code 0).
- R10: `rd_data` returns the last written fields at the positions named above, with bits 23:18 reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal (multiplied) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe for the control word |
| wr_data | input | 24 | Control word to write |
| rd_data | output | 24 | Current control word |
| ref_edge | input | 1 | High for one cycle at a reference-clock edge |
| pll_lock | input | 1 | PLL lock indication |
| stop_req | input | 1 | Level request for the STOP state |
| div_en | output | 1 | Divided clock enable pulse |
| ckout_en | output | 1 | Clock-out enable, aligned with the divided clock |
| stall | output | 1 | Request to lengthen the current processor cycle |
| xtal_force_hi | output | 1 | Crystal output held at logic 1 |
| xtal_drv_en | output | 1 | Crystal oscillator drive active |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
Two functions can meet in one cycle: the write of a new division code and the interval end that would apply it. A third meeting is the realignment wait and the `ref_edge` that releases it. The bench places a write two cycles into an interval of a known length. It then counts the cycles to the next two pulses and expects the old length followed by the new one. With reference edges held off, it confirms that the boundary pulse is the last one while `stall` stays high. It then gives a single `ref_edge` and checks the exact cycles where `stall` falls and the first new pulse appears.

// File: rtl/clkdiv_pwrctl.sv
module clkdiv_pwrctl #(
  parameter int DF_W         = 4,
  parameter int MF_W         = 12,
  parameter int MF_ALIGN_MAX = 4,
  parameter int SETTLE_CYC   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [23:0] wr_data,
  output logic [23:0] rd_data,
  input  logic        ref_edge,
  input  logic        pll_lock,
  input  logic        stop_req,
  output logic        div_en,
  output logic        ckout_en,
  output logic        stall,
  output logic        xtal_force_hi,
  output logic        xtal_drv_en,
  output logic        pll_en,
  output logic        osc_en
);
  localparam int REG_W    = 24;
  localparam int CNT_W    = (1 << DF_W) - 1;
  localparam int DF_LO    = MF_W;
  localparam int XD_BIT   = MF_W + DF_W;
  localparam int KEEP_BIT = XD_BIT + 1;
  localparam int SET_W    = $clog2(SETTLE_CYC + 1);

  typedef enum logic [1:0] {PS_RUN, PS_STOP, PS_RELOCK} pstate_t;

  logic [MF_W-1:0]  reg_mf;
  logic [DF_W-1:0]  reg_df, cur_df;
  logic             reg_xd, reg_keep;
  logic [CNT_W-1:0] cnt;
  logic             align_req, align_wait;
  logic [SET_W-1:0] settle;
  pstate_t          pst;

  wire [DF_W-1:0]  wr_df   = wr_data[DF_LO +: DF_W];
  wire [MF_W-1:0]  wr_mf   = wr_data[MF_W-1:0];
  wire [CNT_W-1:0] mask    = ~({CNT_W{1'b1}} << cur_df);
  wire             running = (pst == PS_RUN);
  wire             at_wrap = running && !align_wait && (cnt == mask);
  wire             pend    = (reg_df != cur_df);
  wire             low_mf  = (wr_mf <= MF_W'(MF_ALIGN_MAX));

  assign div_en        = at_wrap;
  assign ckout_en      = at_wrap;
  assign stall         = align_req;
  assign pll_en        = !(pst == PS_STOP && !reg_keep);
  assign osc_en        = pll_en;
  assign xtal_force_hi = reg_xd;
  assign xtal_drv_en   = !reg_xd && osc_en;
  assign rd_data       = REG_W'({reg_keep, reg_xd, reg_df, reg_mf});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_mf   <= '0;
      reg_df   <= '0;
      reg_xd   <= 1'b0;
      reg_keep <= 1'b0;
    end else if (wr_en) begin
      reg_mf   <= wr_mf;
      reg_df   <= wr_df;
      reg_xd   <= wr_data[XD_BIT];
      reg_keep <= wr_data[KEEP_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      cur_df     <= '0;
      align_wait <= 1'b0;
    end else begin
      if (!running || align_wait || cnt == mask) cnt <= '0;
      else                                       cnt <= cnt + 1'b1;
      if (at_wrap && pend) begin
        cur_df     <= reg_df;
        align_wait <= align_req;
      end else if (align_wait && ref_edge) begin
        align_wait <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      align_req <= 1'b0;
    else if (wr_en)                  align_req <= (low_mf && wr_df != cur_df) || (align_wait && !ref_edge);
    else if (align_wait && ref_edge) align_req <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst    <= PS_RUN;
      settle <= '0;
    end else begin
      case (pst)
        PS_RUN: begin
          settle <= '0;
          if (stop_req) pst <= PS_STOP;
        end
        PS_STOP: begin
          settle <= '0;
          if (!stop_req) pst <= reg_keep ? PS_RUN : PS_RELOCK;
        end
        PS_RELOCK: begin
          if (stop_req) begin
            pst    <= PS_STOP;
            settle <= '0;
          end else if (pll_lock) begin
            if (settle == SET_W'(SETTLE_CYC - 1)) begin
              pst    <= PS_RUN;
              settle <= '0;
            end else begin
              settle <= settle + 1'b1;
            end
          end else begin
            settle <= '0;
          end
        end
        default: pst <= PS_RUN;
      endcase
    end
  end
endmodule

module clkdiv_pwrctl_chk #(
  parameter int MF_W         = 12,
  parameter int MF_ALIGN_MAX = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [23:0] wr_data,
  input logic [23:0] rd_data,
  input logic        ref_edge,
  input logic        stop_req,
  input logic        div_en,
  input logic        stall,
  input logic        xtal_force_hi,
  input logic        xtal_drv_en,
  input logic        pll_en,
  input logic        osc_en
);
  localparam int KEEP_BIT = 17;

  a_r8_no_div_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && stop_req && $past(stop_req)) |-> !div_en);

  a_r9_shutdown_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && stop_req && $past(stop_req) && !rd_data[KEEP_BIT]) |-> (!pll_en && !osc_en));

  a_r5_no_stall_high_mf: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[MF_W-1:0] > MF_W'(MF_ALIGN_MAX) && !stall) |=> !stall);

  a_r4_stall_ends_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(stall)) |-> ($past(ref_edge) || $past(wr_en)));

  a_r7_xtal_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    xtal_force_hi |-> !xtal_drv_en);
endmodule

bind clkdiv_pwrctl clkdiv_pwrctl_chk #(.MF_W(MF_W), .MF_ALIGN_MAX(MF_ALIGN_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .ref_edge(ref_edge), .stop_req(stop_req), .div_en(div_en), .stall(stall),
  .xtal_force_hi(xtal_force_hi), .xtal_drv_en(xtal_drv_en), .pll_en(pll_en), .osc_en(osc_en)
);

// File: tb/clkdiv_pwrctl_tb_top.sv
`timescale 1ns/1ps
module clkdiv_pwrctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic [23:0] rd_data;
  logic ref_man = 1'b0, ref_gen = 1'b0, ref_auto = 1'b0;
  logic ref_edge;
  logic pll_lock = 1'b1;
  logic stop_req = 1'b0;
  logic div_en, ckout_en, stall, xtal_force_hi, xtal_drv_en, pll_en, osc_en;
  int n_chk = 0, n_bad = 0, mon_cnt = 0, mon_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign ref_edge = ref_auto ? ref_gen : ref_man;

  clkdiv_pwrctl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ref_edge(ref_edge), .pll_lock(pll_lock), .stop_req(stop_req), .div_en(div_en),
    .ckout_en(ckout_en), .stall(stall), .xtal_force_hi(xtal_force_hi),
    .xtal_drv_en(xtal_drv_en), .pll_en(pll_en), .osc_en(osc_en)
  );

  localparam int NV = 6;
  localparam int VEC_DF [NV] = '{1, 4, 0, 6, 10, 3};
  localparam int VEC_MF [NV] = '{8, 2, 9, 3, 12, 1};

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      ref_gen = (k % 5 == 0);
    end
  end

  always @(negedge clk) if (rst_n) begin
    mon_cnt++;
    if (ckout_en !== div_en) mon_bad++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] word(input int mf, input int df, input bit xd, input bit keep);
    return 24'((mf & 12'hfff) | ((df & 15) << 12) | (int'(xd) << 16) | (int'(keep) << 17));
  endfunction

  task automatic write_reg(input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!div_en && g < 70000);
  endtask

  task automatic interval(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_en && n < 70000);
  endtask

  initial begin
    int n, p;
    logic [23:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_data == 24'h0, "R1 rd_data", rd_data, 0);
    chk(stall == 1'b0, "R1 stall", stall, 0);
    chk(pll_en && osc_en, "R1 enables", {pll_en, osc_en}, 3);
    chk(xtal_force_hi == 1'b0 && xtal_drv_en == 1'b1, "R1 xtal", {xtal_force_hi, xtal_drv_en}, 1);
    p = 0;
    for (int i = 0; i < 4; i++) begin
      if (div_en) p++;
      @(negedge clk);
    end
    chk(p == 4, "R1 divide-by-one pulses", p, 4);

    // R2 table walk, R10 read-back
    ref_auto = 1'b1;
    for (int i = 0; i < NV; i++) begin
      w = word(VEC_MF[i], VEC_DF[i], 1'b0, 1'b0);
      write_reg(w);
      chk(rd_data == w, "R10 read-back", rd_data, w);
      wait_pulse(); wait_pulse(); wait_pulse();
      interval(n);
      chk(n == (1 << VEC_DF[i]), "R2 interval", n, 1 << VEC_DF[i]);
    end
    ref_auto = 1'b0;

    // R3 shrink 8 -> 4 with write two cycles into the interval
    write_reg(word(8, 3, 0, 0));
    wait_pulse(); wait_pulse();
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 2) begin wr_en = 1'b1; wr_data = word(8, 2, 0, 0); end
      if (n == 3) wr_en = 1'b0;
    end while (!div_en && n < 1000);
    chk(n == 8, "R3 old interval kept (shrink)", n, 8);
    interval(n);
    chk(n == 4, "R3 new interval (shrink)", n, 4);
    // R3 grow 4 -> 16
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin wr_en = 1'b1; wr_data = word(8, 4, 0, 0); end
      if (n == 2) wr_en = 1'b0;
    end while (!div_en && n < 1000);
    chk(n == 4, "R3 old interval kept (grow)", n, 4);
    interval(n);
    chk(n == 16, "R3 new interval (grow)", n, 16);

    // R4 low factor: stall and realignment on ref_edge
    write_reg(word(2, 1, 0, 0));
    chk(stall == 1'b1, "R4 stall rises after write", stall, 1);
    p = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (div_en) p++;
    end
    chk(p == 1, "R4 only boundary pulse before ref_edge", p, 1);
    chk(stall == 1'b1, "R4 stall held while waiting", stall, 1);
    ref_man = 1'b1;
    @(negedge clk);
    ref_man = 1'b0;
    chk(stall == 1'b0 && div_en == 1'b0, "R4 stall falls after ref_edge", {stall, div_en}, 0);
    @(negedge clk);
    chk(div_en == 1'b1, "R4 first pulse two cycles after ref_edge", div_en, 1);

    // R5 high factor: no stall, no ref needed
    write_reg(word(9, 3, 0, 0));
    chk(stall == 1'b0, "R5 no stall after write", stall, 0);
    p = 0;
    wait_pulse();
    if (stall) p++;
    interval(n);
    if (stall) p++;
    chk(n == 8, "R5 new ratio without ref_edge", n, 8);
    chk(p == 0, "R5 stall stayed low", p, 0);

    // R7 crystal disable
    w = word(9, 3, 1, 0);
    write_reg(w);
    chk(xtal_force_hi == 1'b1 && xtal_drv_en == 1'b0, "R7 xtal held high", {xtal_force_hi, xtal_drv_en}, 2);
    chk(rd_data == w, "R10 bit16 read-back", rd_data, w);
    write_reg(word(9, 3, 0, 0));
    chk(xtal_force_hi == 1'b0 && xtal_drv_en == 1'b1, "R7 xtal drive restored", {xtal_force_hi, xtal_drv_en}, 1);

    // R8 STOP with keep bit set
    w = word(9, 0, 0, 1);
    write_reg(w);
    chk(rd_data == w, "R10 bit17 read-back", rd_data, w);
    repeat (20) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    chk(pll_en && osc_en && xtal_drv_en, "R8 enables kept in STOP", {pll_en, osc_en, xtal_drv_en}, 7);
    p = 0;
    for (int i = 0; i < 6; i++) begin
      if (div_en) p++;
      @(negedge clk);
    end
    chk(p == 0, "R8 no pulses in STOP", p, 0);
    stop_req = 1'b0;
    chk(div_en == 1'b0, "R8 last STOP cycle quiet", div_en, 0);
    @(negedge clk);
    chk(div_en == 1'b1, "R8 resume on next divided edge", div_en, 1);

    // R9 STOP with keep bit clear
    write_reg(word(9, 0, 0, 0));
    pll_lock = 1'b0;
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    chk(!pll_en && !osc_en && !xtal_drv_en, "R9 shutdown in STOP", {pll_en, osc_en, xtal_drv_en}, 0);
    repeat (3) @(negedge clk);
    stop_req = 1'b0;
    @(negedge clk);
    chk(pll_en && osc_en && xtal_drv_en && !div_en, "R9 enables back, clock held", {pll_en, osc_en, xtal_drv_en, div_en}, 14);
    p = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (div_en) p++;
    end
    chk(p == 0, "R9 no pulses without lock", p, 0);
    pll_lock = 1'b1;
    p = 0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (div_en) p++;
    end
    chk(p == 0, "R9 held during settle", p, 0);
    @(negedge clk);
    chk(div_en == 1'b1, "R9 resume after settle", div_en, 1);

    // R6 clock-out alignment over whole run
    chk(mon_bad == 0 && mon_cnt > 0, "R6 ckout_en tracks div_en", mon_bad, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule